// File: doc/BRIEF.md
# Uncached physical address classifier

This block sorts the physical address of a memory request into one of three classes: ordinary cacheable memory, uncacheable memory-mapped I/O, or internal-register space. A set top address bit selects uncached space. Inside uncached space, a sub-range whose top nibble is all ones is internal-register space. Every other uncached address is I/O.

For I/O the block raises an uncacheable flag and clears a fixed band of address bits before it passes the address on. For internal-register space the address goes through unchanged and is not marked uncacheable. One register offset is answered with a read-zero response. Every other register offset is reported as an unimplemented access. A speculative request never produces either the read-zero response or the error.

All results are registered. They appear one clock after the request, together with an output valid.

Top module: `upa_classifier`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `req_valid` high. Under reset all outputs are zero.
- R2: When `req_addr[43]` is 0, `out_addr` equals the request address and `out_uncache`, `out_rdzero` and `out_err` are all 0.
- R3: When `req_addr[43]` is 1 and `req_addr[42:40]` is not all ones, `out_uncache` is 1 and `out_addr` is the request address with bits 42 down to 35 forced to 0. This holds whatever `req_spec` is.
- R4: When `req_addr[43:40]` is 4'hF (register space), `out_uncache` is 0 and `out_addr` equals the request address.
- R5: A non-speculative register-space request whose bits 39:0 equal 40'hFFFFF00188 gives `out_rdzero`=1 and `out_err`=0.
- R6: A non-speculative register-space request at any other offset gives `out_err`=1 and `out_rdzero`=0.
- R7: When `req_spec` is 1, `out_err` and `out_rdzero` are 0 for every address.
- R8: In the cycle after `req_valid` is low, `out_addr`, `out_uncache`, `out_rdzero` and `out_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 44 | Physical address of the request |
| req_spec | input | 1 | Request is speculative |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_addr | output | 44 | Address after rewriting |
| out_uncache | output | 1 | Address is uncacheable I/O |
| out_rdzero | output | 1 | Register access answered with zero data |
| out_err | output | 1 | Unimplemented register access |

## Verification
The bench sweeps all 512 values of address bits 43:35. Each value is combined with four low-bit patterns (all zeros, all ones, the zero-response offset, and that offset with its lowest bit flipped), and each combination is driven both speculative and non-speculative.

The top-bit sweep separates cached, I/O and register space. It also shows that the strip band clears exactly bits 42:35. The paired low patterns tell the single zero-response offset apart from its nearest neighbour. The speculative pass shows that only the register-space responses are suppressed. Idle cycles that carry a nonzero address check that the outputs return to zero.

// File: rtl/upa_pkg.sv
// Package: shared class encoding for the uncached address classifier.
// Assumes: every user imports it before declaring class-typed signals.
package upa_pkg;
    typedef enum logic [1:0] {
        CLS_CACHED  = 2'd0,
        CLS_IO      = 2'd1,
        CLS_REGSPC  = 2'd2
    } upa_class_e;
endpackage

// File: rtl/upa_decode.sv
// Module: upa_decode
// Classifies an address as cached, uncached I/O or register space.
// Within register space it also decides between the zero-data response
// and the unimplemented error. Both are gated off for speculative requests.
// Assumes: register space lies at the top of uncached space (REG_LO > 0).
module upa_decode
    import upa_pkg::*;
#(
    parameter int ADDR_W  = 44,
    parameter int UNC_BIT = 43,
    parameter int REG_LO  = 40,
    parameter logic [REG_LO-1:0] REG_OFS = 40'hFF_FFF0_0188
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              spec,
    output upa_class_e        cls,
    output logic              zero_hit,
    output logic              fault
);
    localparam int REG_HI = ADDR_W - 1;

    logic in_unc;
    logic in_reg;
    logic ofs_match;

    // Decode the address space from the upper bits.
    always_comb begin
        in_unc    = addr[UNC_BIT];
        in_reg    = in_unc && (&addr[REG_HI:REG_LO]);
        ofs_match = (addr[REG_LO-1:0] == REG_OFS);
    end

    // Select the class and the register-space responses.
    always_comb begin
        if (!in_unc)      cls = CLS_CACHED;
        else if (in_reg)  cls = CLS_REGSPC;
        else              cls = CLS_IO;
        zero_hit = in_reg && ofs_match && !spec;
        fault    = in_reg && !ofs_match && !spec;
    end
endmodule

// File: rtl/upa_rewrite.sv
// Module: upa_rewrite
// Clears a fixed band of address bits for uncached I/O requests and passes
// every other class through unchanged.
// Assumes: STRIP_LO <= STRIP_HI < ADDR_W.
module upa_rewrite
    import upa_pkg::*;
#(
    parameter int ADDR_W   = 44,
    parameter int STRIP_HI = 42,
    parameter int STRIP_LO = 35
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  upa_class_e        cls,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] keep_mask;

    // Build the keep mask one bit at a time from the strip bounds.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        if (i >= STRIP_LO && i <= STRIP_HI) begin : g_clr
            assign keep_mask[i] = 1'b0;
        end else begin : g_keep
            assign keep_mask[i] = 1'b1;
        end
    end

    // Apply the mask only to I/O addresses.
    always_comb begin
        addr_out = (cls == CLS_IO) ? (addr_in & keep_mask) : addr_in;
    end
endmodule

// File: rtl/upa_resp_reg.sv
// Module: upa_resp_reg
// Output register stage. It captures the result one cycle after a valid
// request and holds every field at zero after an idle cycle.
// Assumes: all inputs are stable before the clock edge.
module upa_resp_reg #(
    parameter int ADDR_W = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_uncache,
    input  logic              in_rdzero,
    input  logic              in_err,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_uncache,
    output logic              out_rdzero,
    output logic              out_err
);
    // Register the result, or zeros when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_uncache <= 1'b0;
            out_rdzero  <= 1'b0;
            out_err     <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_addr    <= in_addr;
            out_uncache <= in_uncache;
            out_rdzero  <= in_rdzero;
            out_err     <= in_err;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_addr == '0 && !out_uncache && !out_rdzero && !out_err));
    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_rdzero && out_err));
endmodule

// File: rtl/upa_classifier.sv
// Module: upa_classifier (top)
// Classifies a request's physical address and registers the rewritten
// address and the response flags.
// Assumes: a synchronous active-low reset and one request per cycle at most.
module upa_classifier
    import upa_pkg::*;
#(
    parameter int ADDR_W   = 44,
    parameter int UNC_BIT  = 43,
    parameter int REG_LO   = 40,
    parameter int STRIP_HI = 42,
    parameter int STRIP_LO = 35,
    parameter logic [REG_LO-1:0] REG_OFS = 40'hFF_FFF0_0188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_spec,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_uncache,
    output logic              out_rdzero,
    output logic              out_err
);
    upa_class_e        cls;
    logic              zero_hit;
    logic              fault;
    logic [ADDR_W-1:0] new_addr;
    logic              is_io;

    upa_decode #(
        .ADDR_W(ADDR_W), .UNC_BIT(UNC_BIT), .REG_LO(REG_LO), .REG_OFS(REG_OFS)
    ) u_decode (
        .addr(req_addr), .spec(req_spec), .cls(cls),
        .zero_hit(zero_hit), .fault(fault)
    );

    upa_rewrite #(
        .ADDR_W(ADDR_W), .STRIP_HI(STRIP_HI), .STRIP_LO(STRIP_LO)
    ) u_rewrite (
        .addr_in(req_addr), .cls(cls), .addr_out(new_addr)
    );

    // Flag I/O class as uncacheable.
    always_comb is_io = (cls == CLS_IO);

    upa_resp_reg #(.ADDR_W(ADDR_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid),
        .in_addr(new_addr), .in_uncache(is_io),
        .in_rdzero(zero_hit), .in_err(fault),
        .out_valid(out_valid), .out_addr(out_addr),
        .out_uncache(out_uncache), .out_rdzero(out_rdzero), .out_err(out_err)
    );

    // R2
    cached_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[UNC_BIT]) |=>
            (out_addr == $past(req_addr) && !out_uncache && !out_err && !out_rdzero));
    // R3
    strip_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_uncache |-> (out_addr[STRIP_HI:STRIP_LO] == '0));
    // R7
    spec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_spec) |=> (!out_err && !out_rdzero));
    // R4
    regspc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&req_addr[ADDR_W-1:REG_LO])) |=>
            (!out_uncache && out_addr == $past(req_addr)));
endmodule

// File: tb/upa_classifier_test.sv
module upa_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [43:0] req_addr = '0;
    logic        req_spec = 1'b0;
    logic        out_valid;
    logic [43:0] out_addr;
    logic        out_uncache;
    logic        out_rdzero;
    logic        out_err;

    int checks = 0;
    int errors = 0;

    localparam logic [43:0] ZERO_FULL = 44'hFFF_FFF0_0188;
    localparam logic [43:0] STRIP_CLR = ~(44'hFF << 35);

    always #2 clk = ~clk;

    upa_classifier uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_spec(req_spec), .out_valid(out_valid), .out_addr(out_addr),
        .out_uncache(out_uncache), .out_rdzero(out_rdzero), .out_err(out_err)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle and compare against an independently computed result.
    task automatic apply(input logic v, input logic [43:0] a, input logic s);
        logic [43:0] e_addr;
        logic e_unc, e_rz, e_err, regs;
        string tag;
        @(negedge clk);
        req_valid = v; req_addr = a; req_spec = s;
        e_addr = '0; e_unc = 0; e_rz = 0; e_err = 0;
        regs = (a[43:40] == 4'hF);
        if (!v)              tag = "R8";
        else if (!a[43])   begin tag = "R2"; e_addr = a; end
        else if (regs) begin
            e_addr = a;
            e_rz  = (a[39:0] == ZERO_FULL[39:0]) && !s;
            e_err = (a[39:0] != ZERO_FULL[39:0]) && !s;
            tag = s ? "R7" : (e_rz ? "R5" : "R6");
        end else begin
            tag = "R3"; e_unc = 1; e_addr = a & STRIP_CLR;
        end
        @(posedge clk); #1;
        check({tag, "/R1 valid"}, {47'd0, out_valid}, {47'd0, v});
        check({tag, " addr"}, {4'd0, out_addr}, {4'd0, e_addr});
        check({tag, (regs && v) ? "/R4 flags" : " flags"},
              {45'd0, out_uncache, out_rdzero, out_err}, {45'd0, e_unc, e_rz, e_err});
    endtask

    initial begin
        logic [34:0] lows [4];
        lows[0] = '0; lows[1] = '1; lows[2] = ZERO_FULL[34:0]; lows[3] = ZERO_FULL[34:0] ^ 35'd1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {39'd0, out_valid, out_uncache, out_rdzero, out_err, 5'd0}, 48'd0);
        check("R1 reset addr", {4'd0, out_addr}, 48'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int hi = 0; hi < 512; hi++) begin
            for (int l = 0; l < 4; l++) begin
                for (int s = 0; s < 2; s++) begin
                    apply(1'b1, {hi[8:0], lows[l]}, s[0]);
                end
            end
            apply(1'b0, {hi[8:0], lows[1]}, 1'b0);
        end
        apply(1'b1, ZERO_FULL, 1'b0);
        apply(1'b1, ZERO_FULL, 1'b1);
        apply(1'b1, 44'hFFF_FFF0_0189, 1'b0);
        apply(1'b0, ZERO_FULL, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule